// File: doc/BRIEF.md
# Serial Receiver Lock Sequencer

This block is the control state machine of a serial-link receiver. It walks the receiver from power-down to valid parallel data and back again. Releasing the power-down request starts the PLL, which first locks onto the local reference clock. The sequencer then waits for a transition word on the serial stream. On the first such word it drops the active-low lock flag, lets the data outputs carry data, and moves the output clock from the reference to the recovered clock. An optional settle mode inserts a fixed wait between detection and lock.

Once locked, a watchdog measures the gap since the last transition word. If the gap runs out, the sequencer falls back to the reference clock, forces the data low and hunts again. Loss of serial activity has the same effect at once. The PLL, clock recovery, word decoding and the glitch-free clock multiplexer are outside the block. They appear only as input strobes and as the clock-select and switch-pulse outputs. All logic runs on one clock.

Top module: `lock_sequencer`

## Requirements
- R1: When `pwrdn_n` is low at a clock edge, then after that edge `lock_oe`, `data_oe`, `pll_run` and `clk_sel_rec` are 0 and `lock_n` is 1, from any state. This also holds while reset is asserted.
- R2: At the first edge with `pwrdn_n` high after power-down, the outputs become `pll_run`=1, `lock_oe`=1, `lock_n`=1, `data_oe`=1, `data_force_low`=1 and `clk_sel_rec`=0 (reference clock).
- R3: Reference locking gives up if `ref_locked` has not arrived within REF_LOCK_CYCLES cycles, or within REF_LOCK_CYCLES_SS cycles when `ss_mode`=1. The flag `lock_timeout_err` becomes 1 one edge after the last allowed cycle. Locking restarts, and the flag stays set until the next power-down.
- R4: A `tw_seen` strobe with `ser_active`=1 while hunting in base mode (`ss_mode`=0) gives `lock_n`=0, `data_force_low`=0 and `clk_sel_rec`=1 after the next edge.
- R5: With `ss_mode`=1, a detected transition word starts a settle phase of SETTLE_CYCLES cycles. `lock_n` falls at the edge after that phase ends, which is SETTLE_CYCLES+1 edges after the word.
- R6: While locked, 2^WDOG_BITS consecutive cycles without `tw_seen` return the outputs to `lock_n`=1, `data_force_low`=1 and `clk_sel_rec`=0. Hunting then continues, so a later word relocks.
- R7: Every `tw_seen` while locked restarts the watchdog window from zero.
- R8: `ser_active`=0 while settling or locked returns the outputs to the hunting values after the next edge. While `ser_active`=0, `tw_seen` is ignored.
- R9: `clk_sw_pulse` is 1 exactly in the cycle in which `clk_sel_rec` shows a new value, and 0 in all other cycles.
- R10: `tw_seen` during reference locking has no effect: the outputs keep their locking values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Power-down request, low = power down |
| ref_locked | input | 1 | PLL reports lock to the reference clock |
| tw_seen | input | 1 | Transition word detected strobe |
| ser_active | input | 1 | Serial input is switching |
| ss_mode | input | 1 | Extra settle / long reference-lock mode |
| lock_n | output | 1 | Active-low lock flag |
| lock_oe | output | 1 | Drive enable for the lock flag |
| data_oe | output | 1 | Drive enable for the data outputs |
| data_force_low | output | 1 | Force the data outputs low |
| clk_sel_rec | output | 1 | Output clock select, 1 = recovered, 0 = reference |
| clk_sw_pulse | output | 1 | One-cycle pulse on a clock-select change |
| pll_run | output | 1 | PLL run control |
| lock_timeout_err | output | 1 | Reference lock timed out since power-up |

## Verification
The bench targets the exact edge at which the reference timeout fires. A counter that is off by one would raise the error one cycle early or late, in either limit mode. It also counts the settle delay and the watchdog window, once from lock entry and once from a restarting word. A watchdog that ignores restarts would unlock in the middle of a healthy stream. Words arriving during reference locking or without serial activity must leave the flag high; a design that trusted the strobe alone would lock falsely. Finally, the switch pulse is checked on every change of the clock select, including the drop caused by power-down.

// File: rtl/lock_seq_pkg.sv
package lock_seq_pkg;

    typedef enum logic [2:0] {
        ST_PDOWN   = 3'd0,
        ST_REFLOCK = 3'd1,
        ST_HUNT    = 3'd2,
        ST_SETTLE  = 3'd3,
        ST_LOCKED  = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       lock_oe;
        logic       lock_n;
        logic       data_oe;
        logic       force_low;
        logic       clk_sel;
        logic       sw_pulse;
        logic       pll_run;
        logic       err;
    } seq_regs_t;

endpackage

// File: rtl/lock_seq_counter.sv
module lock_seq_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [WIDTH-1:0] term,
    output logic             hit
);

    logic [WIDTH-1:0] cnt_d, cnt_q;

    // terminal reached: compare with >= so a lowered limit still fires
    assign hit = en && !clr && (cnt_q >= term);

    always_comb begin
        cnt_d = cnt_q;
        if (clr || hit) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/lock_seq_decode.sv
module lock_seq_decode
    import lock_seq_pkg::*;
(
    input  seq_state_e st,
    output logic       lock_oe,
    output logic       lock_n,
    output logic       data_oe,
    output logic       force_low,
    output logic       clk_sel,
    output logic       pll_run
);

    always_comb begin
        lock_oe   = (st != ST_PDOWN);
        data_oe   = (st != ST_PDOWN);
        pll_run   = (st != ST_PDOWN);
        lock_n    = (st != ST_LOCKED);
        force_low = (st != ST_LOCKED);
        clk_sel   = (st == ST_LOCKED);
    end

endmodule

// File: rtl/lock_sequencer.sv
module lock_sequencer
    import lock_seq_pkg::*;
#(
    parameter int REF_LOCK_CYCLES    = 16928,
    parameter int REF_LOCK_CYCLES_SS = 33600,
    parameter int SETTLE_CYCLES      = 288,
    parameter int WDOG_BITS          = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwrdn_n,
    input  logic ref_locked,
    input  logic tw_seen,
    input  logic ser_active,
    input  logic ss_mode,
    output logic lock_n,
    output logic lock_oe,
    output logic data_oe,
    output logic data_force_low,
    output logic clk_sel_rec,
    output logic clk_sw_pulse,
    output logic pll_run,
    output logic lock_timeout_err
);

    localparam int REF_MAX  = (REF_LOCK_CYCLES_SS > REF_LOCK_CYCLES) ?
                              REF_LOCK_CYCLES_SS : REF_LOCK_CYCLES;
    localparam int REF_W    = $clog2(REF_MAX + 1);
    localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [REF_W-1:0]    REF_TERM_BASE = REF_W'(REF_LOCK_CYCLES - 1);
    localparam logic [REF_W-1:0]    REF_TERM_SS   = REF_W'(REF_LOCK_CYCLES_SS - 1);
    localparam logic [SETTLE_W-1:0] SETTLE_TERM   = SETTLE_W'(SETTLE_CYCLES - 1);

    seq_regs_t  regs_d, regs_q;
    seq_state_e state_d;
    logic       err_d;
    logic       ref_hit, settle_hit, wdog_hit;
    logic       dec_lock_oe, dec_lock_n, dec_data_oe, dec_force_low, dec_clk_sel, dec_pll_run;

    // ---------------- phase timers ----------------
    lock_seq_counter #(.WIDTH(REF_W)) u_ref_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!pwrdn_n || regs_q.state != ST_REFLOCK || ref_locked),
        .en    (regs_q.state == ST_REFLOCK),
        .term  (ss_mode ? REF_TERM_SS : REF_TERM_BASE),
        .hit   (ref_hit)
    );

    lock_seq_counter #(.WIDTH(SETTLE_W)) u_settle_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!pwrdn_n || regs_q.state != ST_SETTLE || !ser_active),
        .en    (regs_q.state == ST_SETTLE),
        .term  (SETTLE_TERM),
        .hit   (settle_hit)
    );

    lock_seq_counter #(.WIDTH(WDOG_BITS)) u_word_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!pwrdn_n || regs_q.state != ST_LOCKED || tw_seen || !ser_active),
        .en    (regs_q.state == ST_LOCKED),
        .term  ({WDOG_BITS{1'b1}}),
        .hit   (wdog_hit)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_d = regs_q.state;
        err_d   = regs_q.err;
        unique case (regs_q.state)
            ST_PDOWN: begin
                state_d = ST_REFLOCK;
            end
            ST_REFLOCK: begin
                if (ref_locked) begin
                    state_d = ST_HUNT;
                end else if (ref_hit) begin
                    err_d = 1'b1;
                end
            end
            ST_HUNT: begin
                if (tw_seen && ser_active) begin
                    state_d = ss_mode ? ST_SETTLE : ST_LOCKED;
                end
            end
            ST_SETTLE: begin
                if (!ser_active) begin
                    state_d = ST_HUNT;
                end else if (settle_hit) begin
                    state_d = ST_LOCKED;
                end
            end
            ST_LOCKED: begin
                if (!ser_active || wdog_hit) begin
                    state_d = ST_HUNT;
                end
            end
            default: state_d = ST_PDOWN;
        endcase
        if (!pwrdn_n) begin
            state_d = ST_PDOWN;
            err_d   = 1'b0;
        end
    end

    lock_seq_decode u_decode (
        .st        (state_d),
        .lock_oe   (dec_lock_oe),
        .lock_n    (dec_lock_n),
        .data_oe   (dec_data_oe),
        .force_low (dec_force_low),
        .clk_sel   (dec_clk_sel),
        .pll_run   (dec_pll_run)
    );

    always_comb begin
        regs_d           = regs_q;
        regs_d.state     = state_d;
        regs_d.err       = err_d;
        regs_d.lock_oe   = dec_lock_oe;
        regs_d.lock_n    = dec_lock_n;
        regs_d.data_oe   = dec_data_oe;
        regs_d.force_low = dec_force_low;
        regs_d.clk_sel   = dec_clk_sel;
        regs_d.pll_run   = dec_pll_run;
        regs_d.sw_pulse  = (dec_clk_sel != regs_q.clk_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_PDOWN, lock_oe: 1'b0, lock_n: 1'b1, data_oe: 1'b0,
                        force_low: 1'b1, clk_sel: 1'b0, sw_pulse: 1'b0,
                        pll_run: 1'b0, err: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign lock_n           = regs_q.lock_n;
    assign lock_oe          = regs_q.lock_oe;
    assign data_oe          = regs_q.data_oe;
    assign data_force_low   = regs_q.force_low;
    assign clk_sel_rec      = regs_q.clk_sel;
    assign clk_sw_pulse     = regs_q.sw_pulse;
    assign pll_run          = regs_q.pll_run;
    assign lock_timeout_err = regs_q.err;

    // ---------------- assertions ----------------
    a_r1_pdown_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrdn_n |=> (!lock_oe && !data_oe && !pll_run && !clk_sel_rec && lock_n));

    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrdn_n && !pll_run) |=> (pll_run && lock_oe && lock_n && data_force_low && !clk_sel_rec));

    a_r3_err_from_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_timeout_err) |-> (pll_run && lock_n));

    a_r4_lock_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_oe && !lock_n) |-> (clk_sel_rec && data_oe && !data_force_low));

    a_r6_wdog_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_LOCKED && wdog_hit && pwrdn_n) |=> lock_n);

    a_r8_inactive_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_active |=> lock_n);

    a_r9_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_sel_rec) |-> clk_sw_pulse);

    a_r9_pulse_only_change: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sw_pulse |-> !$stable(clk_sel_rec));

endmodule

// File: tb/tb_lock_sequencer.sv
module tb_lock_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int P_REF      = 20;
    localparam int P_REF_SS   = 40;
    localparam int P_SETTLE   = 6;
    localparam int P_WDOG     = 4;
    localparam int WIN        = 1 << P_WDOG;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwrdn_n = 1'b0, ref_locked = 1'b0, tw_seen = 1'b0, ser_active = 1'b0, ss_mode = 1'b0;
    logic lock_n, lock_oe, data_oe, data_force_low, clk_sel_rec, clk_sw_pulse, pll_run, lock_timeout_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lock_sequencer #(
        .REF_LOCK_CYCLES(P_REF), .REF_LOCK_CYCLES_SS(P_REF_SS),
        .SETTLE_CYCLES(P_SETTLE), .WDOG_BITS(P_WDOG)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .ref_locked(ref_locked),
        .tw_seen(tw_seen), .ser_active(ser_active), .ss_mode(ss_mode),
        .lock_n(lock_n), .lock_oe(lock_oe), .data_oe(data_oe),
        .data_force_low(data_force_low), .clk_sel_rec(clk_sel_rec),
        .clk_sw_pulse(clk_sw_pulse), .pll_run(pll_run),
        .lock_timeout_err(lock_timeout_err)
    );

    // vector: [11] pwrdn_n [10] ref_locked [9] tw_seen [8] ser_active [7] ss_mode
    // expected: [6] lock_oe [5] lock_n [4] data_oe [3] force_low [2] clk_sel [1] pulse [0] pll_run
    localparam int NVEC = 12;
    localparam logic [11:0] VEC [NVEC] = '{
        12'b00000_0101000, // R1 power-down
        12'b10000_1111001, // R2 release
        12'b10110_1111001, // R10 word during reference lock
        12'b11000_1111001, // R11-free: reference lock done, hunting
        12'b10010_1111001, // hunting, no word
        12'b10110_1010111, // R4 lock with pulse
        12'b10010_1010101, // R9 pulse ends
        12'b10000_1111011, // R8 inactivity unlock with pulse
        12'b10100_1111001, // R8 word ignored without activity
        12'b10110_1010111, // R4 relock
        12'b00000_0101010, // R1 power-down from lock, R9 pulse
        12'b00000_0101000  // R1 steady
    };

    function automatic string vtag(input int i);
        case (i)
            0, 10, 11: return "R1";
            1, 3, 4:   return "R2";
            2:         return "R10";
            5, 9:      return "R4";
            6:         return "R9";
            default:   return "R8";
        endcase
    endfunction

    function automatic logic [6:0] snap();
        return {lock_oe, lock_n, data_oe, data_force_low, clk_sel_rec, clk_sw_pulse, pll_run};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic pd, input logic rl, input logic tw, input logic sa, input logic ss);
        pwrdn_n = pd; ref_locked = rl; tw_seen = tw; ser_active = sa; ss_mode = ss;
        @(posedge clk);
        #1;
    endtask

    task automatic to_hunt(input logic ss);
        apply(0, 0, 0, 0, ss);
        apply(1, 0, 0, 0, ss);
        apply(1, 1, 0, 1, ss);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: all requirements actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // reset state, R1
        #(CLK_PERIOD * 3);
        chk("R1 reset outputs", 32'(snap()), 32'(7'b0101000));
        chk("R3 reset error flag", 32'(lock_timeout_err), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7]);
            chk(vtag(i), 32'(snap()), 32'(VEC[i][6:0]));
        end

        // R3 base-mode reference timeout
        apply(0, 0, 0, 0, 0);
        apply(1, 0, 0, 0, 0);
        for (int k = 1; k < P_REF; k++) apply(1, 0, 0, 0, 0);
        chk("R3 no error before limit", 32'(lock_timeout_err), 32'd0);
        apply(1, 0, 0, 0, 0);
        chk("R3 error at limit", 32'(lock_timeout_err), 32'd1);
        chk("R3 still locking to reference", 32'(snap()), 32'(7'b1111001));
        apply(1, 1, 0, 1, 0);
        chk("R3 error sticky after lock", 32'(lock_timeout_err), 32'd1);
        apply(1, 0, 1, 1, 0);
        chk("R4 lock after restarted reference phase", 32'(lock_n), 32'd0);
        apply(0, 0, 0, 0, 0);
        chk("R3 error cleared by power-down", 32'(lock_timeout_err), 32'd0);

        // R3 spread mode longer limit
        apply(1, 0, 0, 0, 1);
        for (int k = 1; k < P_REF_SS; k++) apply(1, 0, 0, 0, 1);
        chk("R3 ss no error before long limit", 32'(lock_timeout_err), 32'd0);
        apply(1, 0, 0, 0, 1);
        chk("R3 ss error at long limit", 32'(lock_timeout_err), 32'd1);

        // R5 settle delay
        to_hunt(1);
        apply(1, 0, 1, 1, 1);
        for (int k = 1; k < P_SETTLE; k++) apply(1, 0, 0, 1, 1);
        chk("R5 still unlocked during settle", 32'(lock_n), 32'd1);
        apply(1, 0, 0, 1, 1);
        chk("R5 locked after settle", 32'(snap()), 32'(7'b1010111));

        // R8 activity loss during settle
        to_hunt(1);
        apply(1, 0, 1, 1, 1);
        apply(1, 0, 0, 0, 1);
        for (int k = 0; k < P_SETTLE + 2; k++) apply(1, 0, 0, 1, 1);
        chk("R8 settle aborted by inactivity", 32'(lock_n), 32'd1);

        // R6 watchdog from lock entry
        to_hunt(0);
        apply(1, 0, 1, 1, 0);
        for (int k = 1; k < WIN; k++) apply(1, 0, 0, 1, 0);
        chk("R6 locked until window end", 32'(lock_n), 32'd0);
        apply(1, 0, 0, 1, 0);
        chk("R6 unlock at window end", 32'(snap()), 32'(7'b1111011));
        apply(1, 0, 1, 1, 0);
        chk("R6 hunting continues, relock", 32'(lock_n), 32'd0);

        // R7 word restarts window
        for (int k = 0; k < WIN - 4; k++) apply(1, 0, 0, 1, 0);
        apply(1, 0, 1, 1, 0);
        for (int k = 1; k < WIN; k++) apply(1, 0, 0, 1, 0);
        chk("R7 window restarted by word", 32'(lock_n), 32'd0);
        apply(1, 0, 0, 1, 0);
        chk("R7 unlock after restarted window", 32'(lock_n), 32'd1);

        finish_run();
    end

endmodule